// File: doc/BRIEF.md
# Serial Video Descrambler and Word Aligner

This block sits behind a clock-and-data-recovery stage on a serial digital video link. It takes one received bit per cycle of the recovered bit clock. It removes the transition (NRZI) coding, then reverses the self-synchronizing scrambler. The resulting bit stream is cut into 10-bit video words.

The block finds word boundaries by watching the descrambled stream for the timing-reference preamble. The preamble is one word of all ones followed by two words of all zeros. Whenever the preamble appears, a divide-by-ten bit counter is re-phased, so the next bit starts a new word. The block keeps checking this alignment on every line. A lock flag reports whether the preamble keeps arriving at the phase the counter already expects. A separate flag marks the status word that follows each preamble.

Outputs change once per word. A single-cycle enable at one tenth of the bit rate qualifies each word.

Top module: `sdi_word_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `word_en`, `trs_flag` and `locked` are 0 and `word_out` is 0.
- R2: Each decoded bit is the XOR of the bit received now and the bit received one cycle earlier. After a one-bit disturbance, inverting every following input bit yields the same words, alignment and lock.
- R3: Each descrambled bit is the decoded bit XOR the decoded bits from 4 and 9 cycles earlier (the inverse of x^9 + x^4 + 1). No initialization is needed beyond reset.
- R4: Within a word, the first received bit is bit 0 and the tenth is bit 9 of `word_out`.
- R5: Without a preamble, `word_en` pulses for one cycle in every ten cycles. Each pulse carries the last ten descrambled bits. The word holding the descrambled form of the bit sampled at clock edge k is output after edge k+1.
- R6: When the last 30 descrambled bits read 0x3FF, 0x000, 0x000 (oldest word first), the final 0x000 is output at once with `word_en`. The next ten bits then form the next word.
- R7: `trs_flag` is 1 only together with `word_en`, on the first word after a detected preamble (the status word).
- R8: A preamble found where a word boundary was already due counts as a hit. Two consecutive hits set `locked`, and a hit clears the miss count.
- R9: A preamble found off the expected boundary counts as a miss. So does `LINE_WORDS` words passing with no preamble. Two consecutive misses clear `locked`, and a miss clears the hit count. The counter still re-phases on an off-boundary preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Received serial bit, NRZI coded and scrambled |
| word_out | output | 10 | Aligned, descrambled video word |
| word_en | output | 1 | One-cycle qualifier for `word_out`, word rate |
| locked | output | 1 | Alignment confirmed on consecutive lines |
| trs_flag | output | 1 | Marks the status word that follows a preamble |

## Verification
The inline assertions check on every cycle that:
- the bit counter stays within one word;
- a preamble detection is followed by an all-zero word with `word_en`;
- `trs_flag` never appears without `word_en`;
- `locked` only rises or falls on a word event.

Several behaviours can only be shown by the bench scenarios. These are the exact descrambled word values, LSB-first order, and immunity to polarity inversion. They also include the two-hit and two-miss lock hysteresis across a deliberate one-bit slip, and the loss of lock when preambles stop. The bench covers them by encoding a known line stream and comparing against a behavioural model every cycle.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
  localparam int WORD_W    = 10;
  localparam int PRE_WORDS = 3;
  localparam int TAP_A     = 4;
  localparam int TAP_B     = 9;
endpackage

// File: rtl/sdi_nrzi_descrambler.sv
module sdi_nrzi_descrambler
  import sdi_rx_pkg::*;
#(
  parameter int TA = TAP_A,
  parameter int TB = TAP_B
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic bit_o
);
  logic          prev_q;
  logic [TB-1:0] nz_hist;
  logic          nz_bit;
  logic          clear_bit;

  always_comb begin
    nz_bit    = bit_i ^ prev_q;
    clear_bit = nz_bit ^ nz_hist[TA-1] ^ nz_hist[TB-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      nz_hist <= '0;
      bit_o   <= 1'b0;
    end else begin
      prev_q  <= bit_i;
      nz_hist <= {nz_hist[TB-2:0], nz_bit};
      bit_o   <= clear_bit;
    end
  end
endmodule

// File: rtl/sdi_word_framer.sv
module sdi_word_framer
  import sdi_rx_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int P = PRE_WORDS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         en_o,
  output logic         trs_o,
  output logic         det_o,
  output logic         phase_ok_o,
  output logic         emit_o
);
  localparam int HL = P * W;
  localparam int CW = $clog2(W);

  logic [HL-1:0] hist, hist_nx;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          det, boundary;

  always_comb begin
    hist_nx  = {bit_i, hist[HL-1:1]};
    det      = (hist_nx[W-1:0] == '1) && (hist_nx[HL-1:W] == '0);
    boundary = (cnt == CW'(W - 1));
  end

  assign det_o      = det;
  assign phase_ok_o = boundary;
  assign emit_o     = det | boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      word_o <= '0;
      en_o   <= 1'b0;
      trs_o  <= 1'b0;
    end else begin
      hist  <= hist_nx;
      en_o  <= 1'b0;
      trs_o <= 1'b0;
      if (det) begin
        cnt    <= '0;
        en_o   <= 1'b1;
        word_o <= hist_nx[HL-1:HL-W];
        pend   <= 1'b1;
      end else if (boundary) begin
        cnt    <= '0;
        en_o   <= 1'b1;
        word_o <= hist_nx[HL-1:HL-W];
        trs_o  <= pend;
        pend   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r5_cnt_in_word: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W - 1));
  a_r6_detect_emits_zero: assert property (@(posedge clk) disable iff (rst)
    det |=> (en_o && word_o == '0));
  a_r7_trs_with_en: assert property (@(posedge clk) disable iff (rst)
    trs_o |-> en_o);
endmodule

// File: rtl/sdi_lock_tracker.sv
module sdi_lock_tracker #(
  parameter int LINE_WORDS = 1716,
  parameter int LOCK_N     = 2,
  parameter int UNLOCK_N   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic det_i,
  input  logic phase_ok_i,
  input  logic emit_i,
  output logic locked_o
);
  localparam int GW = $clog2(LINE_WORDS + 1);
  localparam int HW = $clog2(LOCK_N + 1);
  localparam int MW = $clog2(UNLOCK_N + 1);

  logic [GW-1:0] gap;
  logic [HW-1:0] hits;
  logic [MW-1:0] misses;
  logic          hit_ev, miss_ev;

  always_comb begin
    hit_ev  = det_i && phase_ok_i;
    miss_ev = (det_i && !phase_ok_i) ||
              (!det_i && emit_i && gap == GW'(LINE_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap      <= '0;
      hits     <= '0;
      misses   <= '0;
      locked_o <= 1'b0;
    end else begin
      if (det_i || miss_ev) gap <= '0;
      else if (emit_i)      gap <= gap + 1'b1;

      if (hit_ev) begin
        misses <= '0;
        if (hits >= HW'(LOCK_N - 1)) locked_o <= 1'b1;
        else                         hits     <= hits + 1'b1;
      end else if (miss_ev) begin
        hits <= '0;
        if (misses >= MW'(UNLOCK_N - 1)) locked_o <= 1'b0;
        else                             misses   <= misses + 1'b1;
      end
    end
  end

  a_r9_gap_bounded: assert property (@(posedge clk) disable iff (rst)
    gap < GW'(LINE_WORDS));
endmodule

// File: rtl/sdi_word_aligner.sv
module sdi_word_aligner
  import sdi_rx_pkg::*;
#(
  parameter int LINE_WORDS = 1716,
  parameter int LOCK_N     = 2,
  parameter int UNLOCK_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  output logic [WORD_W-1:0] word_out,
  output logic              word_en,
  output logic              locked,
  output logic              trs_flag
);
  logic clear_bit, det, phase_ok, emit;

  sdi_nrzi_descrambler u_desc (
    .clk(clk), .rst(rst), .bit_i(ser_bit), .bit_o(clear_bit)
  );

  sdi_word_framer u_framer (
    .clk(clk), .rst(rst), .bit_i(clear_bit),
    .word_o(word_out), .en_o(word_en), .trs_o(trs_flag),
    .det_o(det), .phase_ok_o(phase_ok), .emit_o(emit)
  );

  sdi_lock_tracker #(
    .LINE_WORDS(LINE_WORDS), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)
  ) u_lock (
    .clk(clk), .rst(rst), .det_i(det), .phase_ok_i(phase_ok),
    .emit_i(emit), .locked_o(locked)
  );

  a_r8_lock_on_preamble: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (word_en && word_out == '0));
  a_r9_unlock_on_word: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> word_en);
endmodule

// File: tb/sdi_word_aligner_tb.sv
module sdi_word_aligner_tb;
  localparam int LW = 24;
  localparam logic [9:0] XYZ = 10'h274;
  localparam logic [9:0] FIRST = 10'h12D;

  logic clk = 1'b0, rst = 1'b1, ser_bit = 1'b0;
  logic [9:0] word_out;
  logic word_en, locked, trs_flag;

  int checks = 0, fails = 0;

  sdi_word_aligner #(.LINE_WORDS(LW)) u_dut (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .word_out(word_out),
    .word_en(word_en), .locked(locked), .trs_flag(trs_flag)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic m_prev; logic [8:0] m_nzh; logic m_dq; logic [29:0] m_hist;
  int m_cnt, m_gap, m_hits, m_miss; logic m_pend;
  logic exp_en, exp_trs, exp_lock; logic [9:0] exp_word;

  always @(posedge clk) begin
    logic b, nz, d, det;
    if (rst) begin
      m_prev = 0; m_nzh = 0; m_dq = 0; m_hist = 0; m_cnt = 0; m_gap = 0;
      m_hits = 0; m_miss = 0; m_pend = 0;
      exp_en = 0; exp_trs = 0; exp_lock = 0; exp_word = 0;
    end else begin
      b = ser_bit; nz = b ^ m_prev; m_prev = b;
      d = nz ^ m_nzh[3] ^ m_nzh[8];
      m_nzh = {m_nzh[7:0], nz};
      m_hist = {m_dq, m_hist[29:1]}; m_dq = d;
      det = (m_hist[9:0] == 10'h3FF) && (m_hist[29:10] == 0);
      exp_en = 0; exp_trs = 0;
      if (det) begin
        exp_en = 1; exp_word = m_hist[29:20];
        if (m_cnt == 9) begin
          m_miss = 0; m_hits++; if (m_hits >= 2) exp_lock = 1;
        end else begin
          m_hits = 0; m_miss++; if (m_miss >= 2) exp_lock = 0;
        end
        m_pend = 1; m_cnt = 0; m_gap = 0;
      end else if (m_cnt == 9) begin
        exp_en = 1; exp_word = m_hist[29:20]; exp_trs = m_pend; m_pend = 0;
        m_cnt = 0; m_gap++;
        if (m_gap >= LW) begin
          m_gap = 0; m_hits = 0; m_miss++; if (m_miss >= 2) exp_lock = 0;
        end
      end else m_cnt++;
    end
  end

  logic saw_trs = 0;
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (word_en !== exp_en || trs_flag !== exp_trs || locked !== exp_lock ||
          (exp_en && word_out !== exp_word)) begin
        fails++;
        $display("FAIL R2/R3/R4/R5/R6/R7/R8/R9 model: en=%b word=%h trs=%b lock=%b exp en=%b word=%h trs=%b lock=%b",
                 word_en, word_out, trs_flag, locked, exp_en, exp_word, exp_trs, exp_lock);
      end
      if (trs_flag) begin
        checks++;
        if (word_out !== XYZ) begin
          fails++; $display("FAIL R7 status word: got %h exp %h", word_out, XYZ);
        end
      end
      if (word_en && saw_trs) begin
        checks++;
        if (word_out !== FIRST) begin
          fails++; $display("FAIL R4 first payload: got %h exp %h", word_out, FIRST);
        end
      end
      if (word_en) saw_trs = trs_flag;
    end
  end

  // stimulus encoder: scramble then NRZI
  logic [8:0] e_h = 0; logic tx = 0; logic inv = 0;

  task automatic send_bit(input logic dbit);
    logic s;
    s = dbit ^ e_h[3] ^ e_h[8];
    e_h = {e_h[7:0], s};
    tx = tx ^ s;
    ser_bit = tx ^ inv;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic send_line(input bit pre, input int ln, input int inv_at);
    if (pre) begin
      send_word(10'h3FF); send_word(10'h000); send_word(10'h000); send_word(XYZ);
    end
    for (int k = 0; k < (pre ? 16 : 20); k++) begin
      if (k == inv_at) inv = ~inv;
      send_word(k == 0 ? FIRST : 10'(10'h040 + ((k * 37 + ln * 11) % 10'h380)));
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++; $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(word_en == 0 && trs_flag == 0 && locked == 0 && word_out == 0,
          "R1 reset outputs", {word_en, trs_flag, locked}, 0);
    rst = 0;
    @(negedge clk);
    check(word_en == 0 && trs_flag == 0 && locked == 0 && word_out == 0,
          "R1 first cycle after reset", {word_en, trs_flag, locked}, 0);
    send_bit(1); send_bit(1); send_bit(0);   // misalign start
    for (int l = 0; l < 2; l++) send_line(1, l, -1);
    check(locked == 0, "R8 one hit not enough", locked, 0);
    send_line(1, 2, -1);
    check(locked == 1, "R8 locked after two hits", locked, 1);
    send_line(1, 3, -1);
    // R2: polarity flips mid-line
    send_line(1, 4, 6);
    send_line(1, 5, -1);
    check(locked == 1, "R2 inverted stream keeps lock", locked, 1);
    // R9: one-bit slip gives a single miss
    send_bit(0);
    send_line(1, 6, -1);
    check(locked == 1, "R9 single miss keeps lock", locked, 1);
    send_line(1, 7, -1);
    send_line(1, 8, -1);
    check(locked == 1, "R6/R8 realigned after slip", locked, 1);
    // R9: preambles stop
    for (int l = 0; l < 3; l++) send_line(0, 9 + l, -1);
    check(locked == 0, "R9 unlock after two gap misses", locked, 0);
    send_line(1, 12, -1);
    send_line(1, 13, -1);
    send_line(1, 14, -1);
    check(locked == 1, "R8 relock", locked, 1);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule